// File: doc/BRIEF.md
# Display RAM Write Address Pointer

This block supplies the write address for a display memory that is organised as 6 byte-wide banks, each 84 columns long. The host first places the pointer with separate column and bank commands. Every data byte it sends after that is written at the current pointer position, and the pointer then steps to the next cell. The column count goes up by one for each byte. When it passes the last column it goes back to zero and moves the bank forward by one. Stepping from the final cell of the final bank brings the pointer back to the origin.

A horizontal mirror bit selects whether the physical column is the logical column or its reflection. The bit is applied only to the address of the write taking place at that moment. It never changes the logical pointer, and it never produces a write of its own. Column or bank commands that carry a value outside the legal range are dropped.

The memory array and the display scan logic sit outside this block. The block's outputs are registered: a one-cycle write enable together with the physical column and bank for that write.

Top module: `ram_ptr_top`

## Requirements
- R1: After reset the write enable is low, the column and bank outputs are 0, and the pointer sits at column 0, bank 0.
- R2: With no set command pending, each data strobe writes at the current logical column, and the column then goes up by one.
- R3: A write at logical column 83 in bank B (B < 5) sends the pointer to column 0 of bank B+1.
- R4: A write at logical column 83 in bank 5 sends the pointer to column 0, bank 0.
- R5: The physical column of a write is 83 minus the logical column when mirrorX is 1 in the strobe cycle, and equals the logical column when mirrorX is 0.
- R6: mirrorX has no effect on the logical pointer sequence. Changing mirrorX without a strobe produces no write.
- R7: A set command with a legal value (column 0..83, bank 0..5) loads that coordinate, and the next write uses it.
- R8: A set command with a column value of 84 or more, or a bank value of 6 or more, is ignored, and the pointer keeps its value.
- R9: When a legal set command and a data strobe occur in the same cycle, the write uses the pointer as it was before the set. The loaded value then replaces the pointer, and the increment for that strobe is dropped.
- R10: wrEn is high for exactly the one cycle after each strobe cycle and low otherwise. wrCol and wrBank are valid in that cycle and always lie inside the legal ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setXValid | input | 1 | Load the logical column with setXValue |
| setXValue | input | 7 | Column value to load |
| setYValid | input | 1 | Load the bank with setYValue |
| setYValue | input | 3 | Bank value to load |
| dataStrobe | input | 1 | One data byte is being written |
| mirrorX | input | 1 | Horizontal mirror select |
| wrEn | output | 1 | Write enable, one cycle per strobe |
| wrCol | output | 7 | Physical column of the write |
| wrBank | output | 3 | Bank of the write |

## Verification
All results from a strobe show up exactly one clock after the edge that samples the strobe. The bench drives its inputs on the falling edge and samples the outputs on the next falling edge, so each write is read half a cycle after it is registered. The driver pushes the expected column and bank for each strobe when it drives it. The monitor pops one item for every cycle in which wrEn is high, and a write enable with nothing queued counts as a failure. Set commands and mirror toggles have no output of their own, so their effect, or the lack of one, is checked through the address of the next write.

// File: rtl/ram_ptr_pkg.sv
package ram_ptr_pkg;
  typedef struct packed {
    logic loadX;
    logic loadY;
    logic advance;
    logic capture;
  } ptr_strobes_t;
endpackage

// File: rtl/ram_ptr_ctrl.sv
module ram_ptr_ctrl
  import ram_ptr_pkg::*;
#(
  parameter int COLS  = 84,
  parameter int BANKS = 6,
  localparam int COL_W  = $clog2(COLS),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setXValid,
  input  logic [COL_W-1:0]  setXValue,
  input  logic              setYValid,
  input  logic [BANK_W-1:0] setYValue,
  input  logic              dataStrobe,
  output ptr_strobes_t      strb,
  output logic              wrEn
);
  logic legalX, legalY;

  always_comb begin
    legalX       = int'(setXValue) < COLS;
    legalY       = int'(setYValue) < BANKS;
    strb.loadX   = setXValid && legalX;
    strb.loadY   = setYValid && legalY;
    // a legal set in the strobe cycle takes precedence over the step
    strb.advance = dataStrobe && !strb.loadX && !strb.loadY;
    strb.capture = dataStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrEn <= 1'b0;
    else       wrEn <= dataStrobe;
  end
endmodule

// File: rtl/ram_ptr_dpath.sv
module ram_ptr_dpath
  import ram_ptr_pkg::*;
#(
  parameter int COLS  = 84,
  parameter int BANKS = 6,
  localparam int COL_W  = $clog2(COLS),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptr_strobes_t      strb,
  input  logic [COL_W-1:0]  setXValue,
  input  logic [BANK_W-1:0] setYValue,
  input  logic              mirrorX,
  output logic [COL_W-1:0]  wrCol,
  output logic [BANK_W-1:0] wrBank
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);

  logic [COL_W-1:0]  curX, nextX, physX;
  logic [BANK_W-1:0] curY, nextY;
  logic              colWrap;

  always_comb begin
    colWrap = (curX == LAST_COL);
    nextX   = curX;
    nextY   = curY;
    if (strb.advance) begin
      nextX = colWrap ? '0 : curX + 1'b1;
      if (colWrap) nextY = (curY == LAST_BANK) ? '0 : curY + 1'b1;
    end
    if (strb.loadX) nextX = setXValue;
    if (strb.loadY) nextY = setYValue;
    physX = mirrorX ? (LAST_COL - curX) : curX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curX   <= '0;
      curY   <= '0;
      wrCol  <= '0;
      wrBank <= '0;
    end else begin
      curX <= nextX;
      curY <= nextY;
      if (strb.capture) begin
        wrCol  <= physX;
        wrBank <= curY;
      end
    end
  end
endmodule

// File: rtl/ram_ptr_top.sv
module ram_ptr_top
  import ram_ptr_pkg::*;
#(
  parameter int COLS  = 84,
  parameter int BANKS = 6,
  localparam int COL_W  = $clog2(COLS),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setXValid,
  input  logic [COL_W-1:0]  setXValue,
  input  logic              setYValid,
  input  logic [BANK_W-1:0] setYValue,
  input  logic              dataStrobe,
  input  logic              mirrorX,
  output logic              wrEn,
  output logic [COL_W-1:0]  wrCol,
  output logic [BANK_W-1:0] wrBank
);
  ptr_strobes_t strb;

  ram_ptr_ctrl #(.COLS(COLS), .BANKS(BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .setXValid(setXValid), .setXValue(setXValue),
    .setYValid(setYValid), .setYValue(setYValue),
    .dataStrobe(dataStrobe), .strb(strb), .wrEn(wrEn)
  );

  ram_ptr_dpath #(.COLS(COLS), .BANKS(BANKS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .setXValue(setXValue), .setYValue(setYValue),
    .mirrorX(mirrorX), .wrCol(wrCol), .wrBank(wrBank)
  );
endmodule

// File: rtl/ram_ptr_chk.sv
module ram_ptr_chk #(
  parameter int COLS  = 84,
  parameter int BANKS = 6,
  localparam int COL_W  = $clog2(COLS),
  localparam int BANK_W = $clog2(BANKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              setXValid,
  input logic              setYValid,
  input logic              dataStrobe,
  input logic              mirrorX,
  input logic              wrEn,
  input logic [COL_W-1:0]  wrCol,
  input logic [BANK_W-1:0] wrBank
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(COLS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);

  // R10: one enable per strobe, one cycle later
  a_r10_pulse_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe |=> wrEn);
  a_r10_no_spurious_write: assert property (@(posedge clk) disable iff (!rstN)
    !dataStrobe |=> !wrEn);
  a_r10_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (int'(wrCol) < COLS) && (int'(wrBank) < BANKS));

  // R2, R3, R4: unmirrored back-to-back writes step through the cells
  a_r2_col_steps: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn) && !$past(mirrorX) && !$past(mirrorX, 2)
     && !$past(setXValid, 2) && !$past(setYValid, 2))
    |-> wrCol == (($past(wrCol) == LAST_COL) ? '0 : $past(wrCol) + 1'b1));
  a_r3_bank_steps: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn) && !$past(mirrorX) && !$past(mirrorX, 2)
     && !$past(setXValid, 2) && !$past(setYValid, 2))
    |-> wrBank == (($past(wrCol) != LAST_COL) ? $past(wrBank) :
                   ($past(wrBank) == LAST_BANK) ? '0 : $past(wrBank) + 1'b1));
endmodule

bind ram_ptr_top ram_ptr_chk #(.COLS(COLS), .BANKS(BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .setXValid(setXValid), .setYValid(setYValid),
  .dataStrobe(dataStrobe), .mirrorX(mirrorX), .wrEn(wrEn),
  .wrCol(wrCol), .wrBank(wrBank)
);

// File: tb/sim_ram_ptr_top.sv
module sim_ram_ptr_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       setXValid = 1'b0, setYValid = 1'b0, dataStrobe = 1'b0, mirrorX = 1'b0;
  logic [6:0] setXValue = '0;
  logic [2:0] setYValue = '0;
  logic       wrEn;
  logic [6:0] wrCol;
  logic [2:0] wrBank;

  typedef struct {
    int    col;
    int    bank;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   total = 0, bad = 0;
  int   mdlX = 0, mdlY = 0;
  bit   done = 0;

  ram_ptr_top u0 (.*);

  always #5 clk = ~clk;

  // monitor: each write enable consumes one expected item
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R10: unexpected write col=%0d bank=%0d expected no write", wrCol, wrBank);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (int'(wrCol) != e.col || int'(wrBank) != e.bank) begin
          bad++;
          $display("FAIL %s: col=%0d bank=%0d expected col=%0d bank=%0d",
                   e.tag, wrCol, wrBank, e.col, e.bank);
        end
      end
    end
  end

  function automatic void stepModel();
    if (mdlX == 83) begin
      mdlX = 0;
      mdlY = (mdlY == 5) ? 0 : mdlY + 1;
    end else mdlX++;
  endfunction

  task automatic writeByte(input bit mx, input string tag);
    exp_t e;
    mirrorX = mx;
    dataStrobe = 1'b1;
    e.col = mx ? 83 - mdlX : mdlX;
    e.bank = mdlY;
    e.tag = tag;
    expQ.push_back(e);
    stepModel();
    @(negedge clk);
    dataStrobe = 1'b0;
  endtask

  task automatic setPtr(input bit vx, input int x, input bit vy, input int y, input bit strobe,
                        input string tag);
    bit ldx, ldy;
    exp_t e;
    setXValid = vx; setXValue = 7'(x);
    setYValid = vy; setYValue = 3'(y);
    ldx = vx && x < 84;
    ldy = vy && y < 6;
    if (strobe) begin
      dataStrobe = 1'b1;
      e.col = mirrorX ? 83 - mdlX : mdlX;
      e.bank = mdlY;
      e.tag = tag;
      expQ.push_back(e);
      if (!ldx && !ldy) stepModel();
    end
    if (ldx) mdlX = x;
    if (ldy) mdlY = y;
    @(negedge clk);
    setXValid = 1'b0; setYValid = 1'b0; dataStrobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (wrEn !== 1'b0 || wrCol !== 7'd0 || wrBank !== 3'd0) begin
      bad++;
      $display("FAIL R1: wrEn=%b col=%0d bank=%0d expected 0 0 0", wrEn, wrCol, wrBank);
    end
    // R1, R2: first writes start at origin and step
    writeByte(0, "R1");
    writeByte(0, "R2");
    writeByte(0, "R2");
    @(negedge clk);
    // R7, R3: load near row end, cross into next bank
    setPtr(1, 82, 1, 0, 0, "R7");
    writeByte(0, "R7");
    writeByte(0, "R3");
    writeByte(0, "R3");
    // R4: last cell wraps to origin
    setPtr(1, 83, 1, 5, 0, "R7");
    writeByte(0, "R4");
    writeByte(0, "R4");
    writeByte(0, "R4");
    // R5: mirrored writes
    setPtr(1, 0, 1, 2, 0, "R7");
    writeByte(1, "R5");
    writeByte(1, "R5");
    writeByte(0, "R6");
    // R6: toggling mirror alone makes no write (monitor flags any)
    mirrorX = 1'b1; @(negedge clk);
    mirrorX = 1'b0; @(negedge clk);
    mirrorX = 1'b1; @(negedge clk);
    writeByte(1, "R6");
    mirrorX = 1'b0;
    // R8: out-of-range values ignored
    setPtr(1, 84, 0, 0, 0, "R8");
    setPtr(0, 0, 1, 6, 0, "R8");
    setPtr(1, 127, 1, 7, 0, "R8");
    writeByte(0, "R8");
    // R8: illegal set in strobe cycle leaves the step intact
    setPtr(1, 100, 0, 0, 1, "R8");
    writeByte(0, "R8");
    // R9: legal set alongside strobe
    setPtr(1, 40, 0, 0, 1, "R9");
    writeByte(0, "R9");
    setPtr(0, 0, 1, 3, 1, "R9");
    writeByte(0, "R9");
    // R10: a full bank of back-to-back writes then idle
    for (int i = 0; i < 90; i++) writeByte(0, "R10");
    repeat (4) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R10: %0d writes missing expected 0", expQ.size());
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule